// File: doc/BRIEF.md
# Stereo Soft Mute Ramp

This block sits in a stereo sample path ahead of interpolation and fades the signal to silence when a mute request is raised, then fades it back to unity gain when the request drops. Each left/right pair arrives with a one-cycle sample strobe, and the block acts only on strobes. On a strobe it moves a shared gain counter one step toward silence or toward unity. It then scales both samples by the new gain.

The step size follows a 2-bit speed code, so the fade spans a fixed number of sample periods for each code: one base length, twice that, or four times that. A change of request in the middle of a fade turns it around from the level it has reached, at the same per-sample rate. A flag reports when the gain has reached zero. At that point both outputs are exactly zero.

Top module: `soft_mute_ramp`

## Requirements
- R1: A synchronous reset (`rst` high) clears both outputs and `full_mute` to 0 and sets the gain to unity, so the first strobe after reset passes its samples through unchanged.
- R2: The gain is an integer from 0 to GAIN_FULL = 4*RAMP_BASE. On each strobe it drops by one step when `mute_req` is 1, clamped at 0, and rises by one step when `mute_req` is 0, clamped at GAIN_FULL.
- R3: The step size comes from `speed_mode`: 2'b00 gives 4, 2'b01 gives 2, and 2'b10 and 2'b11 both give 1. Starting from unity with `mute_req` held at 1, `full_mute` rises on exactly strobe RAMP_BASE, 2*RAMP_BASE or 4*RAMP_BASE, in that order of codes.
- R4: When the request changes during a fade, the fade reverses from the present gain without jumping. This holds for a release during a fall and for a re-assertion during a rise.
- R5: Each output equals round(sample*gain/GAIN_FULL), rounding halves toward plus infinity, saturated to the 24-bit two's-complement range. The gain used is the value after that strobe's update, and the output is valid one clock after the strobe.
- R6: `full_mute` is 1 exactly when the gain is 0. It updates on the same clock as the outputs, and while it is 1 both outputs are 0.
- R7: Without a strobe, outputs, flag and gain hold their values, and changes on `mute_req`, `speed_mode` or the sample inputs have no effect.
- R8: Full-scale codes 24'h7FFFFF and 24'h800000 pass unchanged at unity gain and scale without overflow at every other gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| mute_req | input | 1 | Mute request, 1 = fade to silence |
| speed_mode | input | 2 | Ramp length code (00 base, 01 double, 1x quadruple) |
| in_left | input | DATA_W | Left sample, two's complement |
| in_right | input | DATA_W | Right sample, two's complement |
| out_left | output | DATA_W | Scaled left sample |
| out_right | output | DATA_W | Scaled right sample |
| full_mute | output | 1 | Gain has reached zero |

## Verification
The bench builds the block with DATA_W = 24 and RAMP_BASE = 16. The gain range is then 0 to 64, so every fade length, clamp and mid-ramp reversal for all four speed codes can be reached in a few hundred strobes. A reference model recomputes the rounding with real arithmetic for random and full-scale samples on every clock. The fine 1/64 gain resolution exercises the half-up rounding on many fractional products.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [1:0] {
    SPD_BASE   = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_QUAD_B = 2'b11
  } speed_e;

  // log2 of the gain step taken per strobe for a speed code
  function automatic int unsigned step_shift(input logic [1:0] code);
    case (speed_e'(code))
      SPD_BASE:   step_shift = 2;
      SPD_DOUBLE: step_shift = 1;
      default:    step_shift = 0;
    endcase
  endfunction

endpackage

// File: rtl/smr_gain_ramp.sv
module smr_gain_ramp #(
  parameter int RAMP_BASE = 1024,
  localparam int GAIN_FULL = RAMP_BASE * 4,
  localparam int GAIN_W    = $clog2(GAIN_FULL) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic              mute_req,
  input  logic [1:0]        speed_mode,
  output logic [GAIN_W-1:0] gain_nxt,
  output logic [GAIN_W-1:0] gain_q,
  output logic              at_floor
);
  import smr_pkg::*;

  localparam logic [GAIN_W-1:0] FULL_G = GAIN_W'(GAIN_FULL);

  logic [GAIN_W-1:0] step;
  logic [GAIN_W:0]   up_sum;
  logic              step_dn, step_up, hit_floor, hit_ceiling;

  assign step        = GAIN_W'(1) << step_shift(speed_mode);
  assign step_dn     = smp_stb && mute_req;
  assign step_up     = smp_stb && !mute_req;
  assign up_sum      = {1'b0, gain_q} + {1'b0, step};
  assign hit_floor   = gain_q <= step;
  assign hit_ceiling = up_sum >= {1'b0, FULL_G};

  always_comb begin
    gain_nxt = gain_q;
    if (step_dn) gain_nxt = hit_floor ? '0 : gain_q - step;
    else if (step_up) gain_nxt = hit_ceiling ? FULL_G : up_sum[GAIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) gain_q <= FULL_G;
    else     gain_q <= gain_nxt;
  end

  assign at_floor = gain_q == '0;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  a_r2_gain_in_range: assert property (@(posedge clk) disable iff (rst)
    gain_q <= FULL_G);
  a_r2_fall_dir: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(step_dn) |-> gain_q <= $past(gain_q));
  a_r4_rise_dir: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(step_up) |-> gain_q >= $past(gain_q));
  a_r7_gain_hold: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(smp_stb) |-> $stable(gain_q));

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 13,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] sample,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] scaled
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] RND_HALF = PROD_W'(1) << (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] POS_MAX  = PROD_W'((64'(1) << (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] NEG_MIN  = -POS_MAX - PROD_W'(1);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC_W;

  // round half up, then clip to the sample range
  function automatic logic [DATA_W-1:0] scale_fn(
    input logic [DATA_W-1:0] s, input logic [GAIN_W-1:0] g);
    logic signed [PROD_W-1:0] p, q;
    p = PROD_W'($signed(s)) * $signed({1'b0, g});
    q = (p + RND_HALF) >>> FRAC_W;
    if (q > POS_MAX)      q = POS_MAX;
    else if (q < NEG_MIN) q = NEG_MIN;
    return q[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          scaled <= '0;
    else if (smp_stb) scaled <= scale_fn(sample, gain);
  end

  a_r5_unity_pass: assert property (@(posedge clk) disable iff (rst)
    smp_stb && gain == UNITY |=> scaled == $past(sample));
  a_r6_zero_gain: assert property (@(posedge clk) disable iff (rst)
    smp_stb && gain == '0 |=> scaled == '0);

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DATA_W    = 24,
  parameter int RAMP_BASE = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic              mute_req,
  input  logic [1:0]        speed_mode,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              full_mute
);
  localparam int GAIN_FULL = RAMP_BASE * 4;
  localparam int FRAC_W    = $clog2(GAIN_FULL);
  localparam int GAIN_W    = FRAC_W + 1;
  localparam int N_CH      = 2;

  logic [GAIN_W-1:0] gain_nxt, gain_q;
  logic              at_floor;
  logic [DATA_W-1:0] ch_in  [N_CH];
  logic [DATA_W-1:0] ch_out [N_CH];

  smr_gain_ramp #(.RAMP_BASE(RAMP_BASE)) u_ramp (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .mute_req(mute_req),
    .speed_mode(speed_mode), .gain_nxt(gain_nxt), .gain_q(gain_q),
    .at_floor(at_floor)
  );

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    smr_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_scl (
      .clk(clk), .rst(rst), .smp_stb(smp_stb), .sample(ch_in[c]),
      .gain(gain_nxt), .scaled(ch_out[c])
    );
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];
  assign full_mute = at_floor;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  a_r6_silent_when_flagged: assert property (@(posedge clk) disable iff (rst)
    full_mute |-> out_left == '0 && out_right == '0);
  a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(smp_stb) |-> $stable(out_left) && $stable(out_right) && $stable(full_mute));
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> out_left == '0 && out_right == '0 && !full_mute);

endmodule

// File: tb/sim_soft_mute_ramp.sv
module sim_soft_mute_ramp;
  localparam int DW = 24;
  localparam int RB = 16;
  localparam int GF = RB * 4;

  logic clk = 0, rst = 1, stb = 0, mute = 0;
  logic [1:0] mode = 0;
  logic [DW-1:0] inl = 0, inr = 0;
  logic [DW-1:0] outl, outr;
  logic full;

  soft_mute_ramp #(.DATA_W(DW), .RAMP_BASE(RB)) u0 (
    .clk(clk), .rst(rst), .smp_stb(stb), .mute_req(mute), .speed_mode(mode),
    .in_left(inl), .in_right(inr), .out_left(outl), .out_right(outr),
    .full_mute(full)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int ref_g = GF;
  logic [DW-1:0] exp_l = 0, exp_r = 0;

  function automatic logic [DW-1:0] ref_scale(input logic [DW-1:0] x, input int g);
    real v;
    longint q;
    v = $floor((real'($signed(x)) * g + GF / 2.0) / GF);
    q = longint'(v);
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return q[DW-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input bit s, input bit m, input logic [1:0] md,
                      input logic [DW-1:0] l, input logic [DW-1:0] r, input string req);
    int st;
    @(negedge clk);
    stb = s; mute = m; mode = md; inl = l; inr = r;
    @(posedge clk);
    #1;
    if (s) begin
      st = (md == 2'b00) ? 4 : (md == 2'b01) ? 2 : 1;
      if (m) ref_g = (ref_g - st < 0) ? 0 : ref_g - st;
      else   ref_g = (ref_g + st > GF) ? GF : ref_g + st;
      exp_l = ref_scale(l, ref_g);
      exp_r = ref_scale(r, ref_g);
    end
    check(outl == exp_l, {req, " left"}, outl, exp_l);
    check(outr == exp_r, {req, " right"}, outr, exp_r);
    check(full == (ref_g == 0), {req, " flag"}, full, ref_g == 0);
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom);
  endfunction

  task automatic ramp_len(input logic [1:0] md, input int expect_n, input string req);
    int n = 0;
    while (!full && n < 10 * GF) begin
      tick(1, 1, md, rnd(), rnd(), "R5");
      n++;
    end
    check(n == expect_n, req, n, expect_n);
    for (int i = 0; i < expect_n; i++) tick(1, 0, md, rnd(), rnd(), "R2");
    tick(1, 0, md, 24'h7FFFFF, 24'h800000, "R8");
    check(outl == 24'h7FFFFF, "R2 back at unity", outl, 24'h7FFFFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(outl == 0 && outr == 0, "R1 outputs after reset", {outl, outr}, 0);
    check(full == 0, "R1 flag after reset", full, 0);
    @(negedge clk); rst = 0;
    tick(1, 0, 2'b00, 24'h123456, 24'hFEDCBA, "R1");
    check(outl == 24'h123456, "R1 unity pass", outl, 24'h123456);
    tick(1, 0, 2'b00, 24'h7FFFFF, 24'h800000, "R8");
    tick(1, 0, 2'b00, 24'h800000, 24'h7FFFFF, "R8");

    ramp_len(2'b00, RB, "R3 base length");
    ramp_len(2'b01, 2 * RB, "R3 double length");
    ramp_len(2'b10, 4 * RB, "R3 quad length");
    ramp_len(2'b11, 4 * RB, "R3 code 11 length");

    // R4: release mid-fall, then re-assert mid-rise
    for (int i = 0; i < 5; i++) tick(1, 1, 2'b00, 24'h7FFFFF, 24'h800000, "R4");
    check(ref_g == GF - 20, "R4 level after fall", ref_g, GF - 20);
    for (int i = 0; i < 2; i++) tick(1, 0, 2'b00, 24'h7FFFFF, 24'h800000, "R4");
    check(outl == ref_scale(24'h7FFFFF, GF - 12), "R4 reversed up", outl, ref_scale(24'h7FFFFF, GF - 12));
    for (int i = 0; i < 3; i++) tick(1, 1, 2'b01, 24'h400001, 24'hBFFFFF, "R4");
    check(outr == ref_scale(24'hBFFFFF, GF - 18), "R4 reversed down", outr, ref_scale(24'hBFFFFF, GF - 18));

    // R7: no strobe, everything else toggles
    for (int i = 0; i < 6; i++) tick(0, i[0], 2'(i), rnd(), rnd(), "R7");
    tick(1, 0, 2'b10, 24'h000001, 24'hFFFFFF, "R7");
    check(ref_g == GF - 17, "R7 gain untouched without strobe", ref_g, GF - 17);

    // R6: reach floor and stay there, outputs exactly zero
    for (int i = 0; i < GF; i++) tick(1, 1, 2'b00, 24'h7FFFFF, 24'h800000, "R6");
    check(outl == 0 && outr == 0 && full, "R6 floor silent", {outl, outr}, 0);

    // R1: reset mid-mute restores unity
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    ref_g = GF; exp_l = 0; exp_r = 0;
    #1;
    check(outl == 0 && full == 0, "R1 reset mid-mute", {outl, full}, 0);
    tick(1, 0, 2'b00, 24'h654321, 24'h800000, "R1");
    check(outl == 24'h654321, "R1 unity after reset", outl, 24'h654321);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule